// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of a synchronous DRAM interface. It moves the memory into self-refresh and brings it back out, and it keeps the command pins and the clock-enable pin to the required order and spacing while it does so. When the controller asks for entry, the sequencer issues a precharge to all banks and then counts out the row-precharge delay. It then drops clock-enable in the same cycle that it issues an auto-refresh command. Clock-enable stays low for as long as the controller wants, with no upper limit.

For exit, the controller raises an exit request and confirms that the memory clock is stable. The sequencer raises clock-enable and issues only no-operation commands for the exit recovery window. That window is counted in clocks and is never shorter than two cycles. After the window it issues one auto-refresh to restart the refresh time base and pulses a done flag for one cycle. Delays are given in picoseconds together with the clock period, and the sequencer turns them into cycle counts when it is elaborated.

Top module: `sdram_sref_seq`

## Requirements
- R1: While reset is active and after it is released, the sequencer issues no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1), with cke=1, all-bank bit 0, busy=0 and done=0.
- R2: An entry request sampled at a clock edge while idle produces, in the next cycle, a precharge command (cs_n=0, ras_n=0, cas_n=1, we_n=0) with the all-bank bit at 1, cke=1 and busy=1.
- R3: The cycles between the precharge and the refresh carry no-operation with cke=1. The refresh comes G cycles after the precharge, where G = ceil(tRP/tCK) with a lower bound of 2.
- R4: The auto-refresh command (cs_n=0, ras_n=0, cas_n=0, we_n=1) is issued in the same cycle in which cke first goes low.
- R5: During self-refresh, cke stays low and the command pins show command-inhibit (cs_n=1, ras_n=1, cas_n=1, we_n=1) for any length of time. Entry requests have no effect, and clk_stable alone never ends self-refresh.
- R6: cke returns high in the cycle after an edge at which clk_stable=1 and an exit request is either present or pending.
- R7: Starting with the cycle in which cke rises, exactly X cycles carry no-operation with cke=1, where X = ceil(tXSR/tCK) with a lower bound of 2. Entry and exit requests in that window have no effect.
- R8: After the recovery window comes an auto-refresh with cke=1, then one cycle with done=1 and busy=0, and then idle.
- R9: An exit request made at any time from the precharge cycle onward, before self-refresh is reached, is held. Self-refresh then ends as soon as clk_stable is seen high, with no need to request exit again.
- R10: An exit request while idle is ignored and not remembered. A later self-refresh stays entered while clk_stable is high until a new exit request arrives.
- R11: busy is 1 from the precharge cycle through the final auto-refresh cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sref_enter_req | input | 1 | Request to enter self-refresh, sampled while idle |
| sref_exit_req | input | 1 | Request to leave self-refresh |
| clk_stable | input | 1 | Memory clock confirmed stable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_all_banks | output | 1 | Address bit that selects all banks for precharge |
| sref_busy | output | 1 | Sequence in progress |
| sref_done | output | 1 | One-cycle pulse when exit has completed |

## Verification
The assertions assume that requests are sampled synchronously, and that clk_stable is a level that the controller raises only when the memory clock really is stable. They do not check that clock itself. The bench drives every input on the falling edge, so each rising edge sees settled values. While an exit request is pending, it keeps clk_stable low until it decides when exit should happen, which makes the exit edge known in advance. Random requests and clk_stable values are also applied during self-refresh and the recovery window, so the property that those inputs are ignored is exercised under changing inputs.

// File: rtl/sref_pkg.sv
package sref_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_ENTER_SR,
        ST_IN_SR,
        ST_EXIT_XSR,
        ST_POST_REF,
        ST_READY
    } sref_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
        logic all_banks;
        logic busy;
        logic done;
    } sref_pins_t;

    // Whole clock cycles that cover a delay given in picoseconds.
    function automatic int cycles_for(input int t_ps, input int period_ps);
        return (t_ps + period_ps - 1) / period_ps;
    endfunction

    function automatic int at_least(input int value, input int floor_v);
        return (value < floor_v) ? floor_v : value;
    endfunction

endpackage

// File: rtl/sref_wait_cnt.sv
module sref_wait_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sref_cmd_enc.sv
module sref_cmd_enc
    import sref_pkg::*;
(
    input  sref_state_e state,
    output sref_pins_t  pins
);

    always_comb begin
        // default: no-operation with clock enabled
        pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                 cke: 1'b1, all_banks: 1'b0, busy: 1'b1, done: 1'b0};
        unique case (state)
            ST_IDLE: begin
                pins.busy = 1'b0;
            end
            ST_PRECHARGE: begin
                pins.ras_n     = 1'b0;
                pins.we_n      = 1'b0;
                pins.all_banks = 1'b1;
            end
            ST_ENTER_SR: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
                pins.cke   = 1'b0;
            end
            ST_IN_SR: begin
                pins.cs_n = 1'b1;
                pins.cke  = 1'b0;
            end
            ST_POST_REF: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
            end
            ST_READY: begin
                pins.busy = 1'b0;
                pins.done = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sdram_sref_seq.sv
module sdram_sref_seq
    import sref_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int TRP_PS        = 20000,
    parameter int TXSR_PS       = 80000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sref_enter_req,
    input  logic sref_exit_req,
    input  logic clk_stable,
    output logic sd_cs_n,
    output logic sd_ras_n,
    output logic sd_cas_n,
    output logic sd_we_n,
    output logic sd_cke,
    output logic sd_all_banks,
    output logic sref_busy,
    output logic sref_done
);

    localparam int TRP_GAP  = at_least(cycles_for(TRP_PS, CLK_PERIOD_PS), 2);
    localparam int TXSR_CYC = at_least(cycles_for(TXSR_PS, CLK_PERIOD_PS), 2);
    localparam int CNT_MAX  = at_least(TRP_GAP - 2, TXSR_CYC - 1);
    localparam int CNT_W    = $clog2(CNT_MAX + 2);
    localparam logic [CNT_W-1:0] TRP_LOAD  = CNT_W'(TRP_GAP - 2);
    localparam logic [CNT_W-1:0] TXSR_LOAD = CNT_W'(TXSR_CYC - 1);

    typedef struct packed {
        sref_state_e st;
        logic        pend;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    sref_pins_t       pins;

    sref_wait_cnt #(.W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    always_comb begin
        seq_d    = seq_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (seq_q.st)
            ST_IDLE: begin
                seq_d.pend = 1'b0;
                if (sref_enter_req) seq_d.st = ST_PRECHARGE;
            end
            ST_PRECHARGE: begin
                seq_d.pend = seq_q.pend | sref_exit_req;
                seq_d.st   = ST_WAIT_RP;
                cnt_load   = 1'b1;
                cnt_val    = TRP_LOAD;
            end
            ST_WAIT_RP: begin
                seq_d.pend = seq_q.pend | sref_exit_req;
                if (cnt_zero) seq_d.st = ST_ENTER_SR;
            end
            ST_ENTER_SR: begin
                seq_d.pend = seq_q.pend | sref_exit_req;
                seq_d.st   = ST_IN_SR;
            end
            ST_IN_SR: begin
                if ((seq_q.pend | sref_exit_req) && clk_stable) begin
                    seq_d.pend = 1'b0;
                    seq_d.st   = ST_EXIT_XSR;
                    cnt_load   = 1'b1;
                    cnt_val    = TXSR_LOAD;
                end else begin
                    seq_d.pend = seq_q.pend | sref_exit_req;
                end
            end
            ST_EXIT_XSR: begin
                if (cnt_zero) seq_d.st = ST_POST_REF;
            end
            ST_POST_REF: seq_d.st = ST_READY;
            ST_READY:    seq_d.st = ST_IDLE;
            default:     seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, pend: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    sref_cmd_enc u_enc (
        .state (seq_q.st),
        .pins  (pins)
    );

    assign sd_cs_n      = pins.cs_n;
    assign sd_ras_n     = pins.ras_n;
    assign sd_cas_n     = pins.cas_n;
    assign sd_we_n      = pins.we_n;
    assign sd_cke       = pins.cke;
    assign sd_all_banks = pins.all_banks;
    assign sref_busy    = pins.busy;
    assign sref_done    = pins.done;

    // ---------------- assertion support and checks ----------------
    logic             cmd_quiet, cmd_pre, cmd_ref;
    logic             cke_prev_q;
    logic [CNT_W-1:0] win_q;

    assign cmd_quiet = sd_cs_n || (sd_ras_n && sd_cas_n && sd_we_n);
    assign cmd_pre   = !sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n;
    assign cmd_ref   = !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_prev_q <= 1'b1;
            win_q      <= '0;
        end else begin
            cke_prev_q <= sd_cke;
            if (sd_cke && !cke_prev_q) begin
                win_q <= TXSR_LOAD;
            end else if (win_q != '0) begin
                win_q <= win_q - 1'b1;
            end
        end
    end

    assert_pre_all_banks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pre |-> sd_all_banks && sd_cke);

    assert_cke_fall_with_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && cke_prev_q) |-> cmd_ref);

    assert_inhibit_in_sref_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cke && !cke_prev_q) |-> sd_cs_n);

    assert_exit_needs_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke && !cke_prev_q) |-> $past(clk_stable));

    assert_xsr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((sd_cke && !cke_prev_q) || win_q != '0) |-> cmd_quiet);

    assert_xsr_two_cycles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke && !cke_prev_q) |=> (cmd_quiet && sd_cke));

    assert_done_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sref_done |-> $past(cmd_ref && sd_cke) && !sref_busy);

endmodule

// File: tb/sdram_sref_seq_bench.sv
module sdram_sref_seq_bench;

    localparam int CLK_PERIOD = 10;

    localparam int A_CLK_PS = 10000, A_TRP_PS = 20000, A_TXSR_PS = 80000;
    localparam int B_CLK_PS = 100000, B_TRP_PS = 15000, B_TXSR_PS = 75000;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_INH = 4'b1111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en = 0, a_ex = 0, a_st = 0;
    logic b_en = 0, b_ex = 0, b_st = 0;
    logic [7:0] a_out, b_out, o;
    int sel = 0;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_sref_seq #(.CLK_PERIOD_PS(A_CLK_PS), .TRP_PS(A_TRP_PS), .TXSR_PS(A_TXSR_PS))
    u_sdram_sref_seq (
        .clk(clk), .rst_n(rst_n),
        .sref_enter_req(a_en), .sref_exit_req(a_ex), .clk_stable(a_st),
        .sd_cs_n(a_out[7]), .sd_ras_n(a_out[6]), .sd_cas_n(a_out[5]), .sd_we_n(a_out[4]),
        .sd_cke(a_out[3]), .sd_all_banks(a_out[2]), .sref_busy(a_out[1]), .sref_done(a_out[0])
    );

    sdram_sref_seq #(.CLK_PERIOD_PS(B_CLK_PS), .TRP_PS(B_TRP_PS), .TXSR_PS(B_TXSR_PS))
    u_sdram_sref_seq_fast (
        .clk(clk), .rst_n(rst_n),
        .sref_enter_req(b_en), .sref_exit_req(b_ex), .clk_stable(b_st),
        .sd_cs_n(b_out[7]), .sd_ras_n(b_out[6]), .sd_cas_n(b_out[5]), .sd_we_n(b_out[4]),
        .sd_cke(b_out[3]), .sd_all_banks(b_out[2]), .sref_busy(b_out[1]), .sref_done(b_out[0])
    );

    assign o = (sel == 0) ? a_out : b_out;

    function automatic int cyc_floor2(input int t_ps, input int p_ps);
        int c;
        c = (t_ps + p_ps - 1) / p_ps;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic int gap_rp();
        return (sel == 0) ? cyc_floor2(A_TRP_PS, A_CLK_PS) : cyc_floor2(B_TRP_PS, B_CLK_PS);
    endfunction

    function automatic int gap_xsr();
        return (sel == 0) ? cyc_floor2(A_TXSR_PS, A_CLK_PS) : cyc_floor2(B_TXSR_PS, B_CLK_PS);
    endfunction

    task automatic tick(input bit en, input bit ex, input bit st);
        if (sel == 0) begin a_en = en; a_ex = ex; a_st = st; end
        else          begin b_en = en; b_ex = ex; b_st = st; end
        @(negedge clk);
    endtask

    task automatic expect_pins(input string tag, input logic [3:0] cmd, input bit cke,
                               input bit ab, input bit busy, input bit done);
        logic [7:0] exp;
        exp = {cmd, cke, ab, busy, done};
        checks++;
        if (o !== exp) begin
            failures++;
            $display("FAIL %s dut=%0d actual=%b expected=%b", tag, sel, o, exp);
        end
    endtask

    task automatic run_sref(input int dwell, input bit early_exit, input bit idle_exit_before);
        bit req_seen;
        bit en, ex, st;
        tick(1, 0, 0);
        expect_pins("R2 precharge-all", C_PRE, 1, 1, 1, 0);
        for (int i = 1; i < gap_rp(); i++) begin
            tick(0, early_exit && i == 1, 0);
            expect_pins("R3 trp wait", C_NOP, 1, 0, 1, 0);
        end
        tick(0, 0, 0);
        expect_pins("R4 refresh with cke low", C_REF, 0, 0, 1, 0);
        tick(0, 0, 0);
        expect_pins("R5 first inhibit", C_INH, 0, 0, 1, 0);
        req_seen = early_exit;
        for (int d = 0; d < dwell; d++) begin
            en = 1'($urandom % 2);
            if (d == 0 && !req_seen) begin
                ex = 0; st = 1;
            end else if (req_seen) begin
                ex = 1'($urandom % 2); st = 0;
            end else begin
                ex = 1'($urandom % 2);
                st = ex ? 1'b0 : 1'($urandom % 2);
            end
            tick(en, ex, st);
            if (req_seen)
                expect_pins("R9 held request waits for clk_stable", C_INH, 0, 0, 1, 0);
            else if (d == 0 && idle_exit_before)
                expect_pins("R10 idle exit not remembered", C_INH, 0, 0, 1, 0);
            else
                expect_pins("R5 stays in self-refresh", C_INH, 0, 0, 1, 0);
            req_seen |= ex;
        end
        tick(0, !req_seen, 1);
        if (early_exit && dwell == 0)
            expect_pins("R9 held exit taken", C_NOP, 1, 0, 1, 0);
        else
            expect_pins("R6 cke rises", C_NOP, 1, 0, 1, 0);
        for (int i = 1; i < gap_xsr(); i++) begin
            tick(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            expect_pins("R7 txsr quiet", C_NOP, 1, 0, 1, 0);
        end
        tick(0, 0, 0);
        expect_pins("R8 post refresh", C_REF, 1, 0, 1, 0);
        tick(0, 0, 0);
        expect_pins("R8 done pulse R11", C_NOP, 1, 0, 0, 1);
        tick(0, 0, 0);
        expect_pins("R11 back to idle", C_NOP, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        expect_pins("R1 during reset", C_NOP, 1, 0, 0, 0);
        rst_n = 1'b1;
        tick(0, 0, 0);
        expect_pins("R1 after reset", C_NOP, 1, 0, 0, 0);

        sel = 0;
        run_sref(0, 1, 0);
        run_sref(4, 0, 0);
        for (int i = 0; i < 3; i++) begin
            tick(0, 1, 1);
            expect_pins("R10 exit in idle ignored", C_NOP, 1, 0, 0, 0);
        end
        run_sref(3, 0, 1);
        for (int r = 0; r < 25; r++) begin
            run_sref(int'($urandom % 12), 1'($urandom % 2), 0);
            for (int k = int'($urandom % 3); k > 0; k--) begin
                tick(0, 0, 1'($urandom % 2));
                expect_pins("R1 idle between runs", C_NOP, 1, 0, 0, 0);
            end
        end

        sel = 1;
        tick(0, 0, 0);
        expect_pins("R1 fast instance idle", C_NOP, 1, 0, 0, 0);
        run_sref(2, 0, 0);
        run_sref(0, 1, 0);
        for (int r = 0; r < 10; r++) begin
            run_sref(int'($urandom % 8), 1'($urandom % 2), 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule